// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a 16-bit code fetch port and an instruction decoder. It holds up to six instruction bytes in arrival order. While it has at least two free byte slots it asks the bus for more code. A fetch to an odd address yields one byte. A fetch to an even address yields two bytes. The decoder removes one byte per read and marks each read as either the first byte of an opcode or a later byte of the same instruction.

When a jump or call changes the flow of control, the decoder pulses `redirect` with the new target. The queue empties in that cycle and fetching restarts at the target. A fetch that was already on the bus still runs to completion, but its data is thrown away. Each cycle a two-bit status code reports what happened to the queue in the cycle before.

The fetch controller is a three-state machine:
- `FS_IDLE` waits for room.
- `FS_WAIT` holds a live request until the bus answers.
- `FS_DROP` holds a request that a redirect has made stale until its data arrives.

Its transitions are:
- FS_IDLE→FS_WAIT when two slots are free and no redirect is pending.
- FS_WAIT→FS_IDLE on return data, which is accepted.
- FS_WAIT→FS_IDLE on a redirect in the same cycle as return data, which is dropped.
- FS_WAIT→FS_DROP on a redirect without return data.
- FS_DROP→FS_IDLE on return data, which is dropped.

Top module: `pfq_top`

## Requirements
- R1: The queue holds at most 6 bytes. With the bus stalled, a full queue yields exactly 6 valid reads and then reports empty.
- R2: `fetch_req` rises only when at least 2 slots were free in the cycle before. If the controller is idle, there is room, and no redirect is pending, `fetch_req` rises on the next cycle.
- R3: Once raised, `fetch_req` stays high with `fetch_addr` unchanged until the cycle in which `bus_rvalid` is high.
- R4: If `fetch_addr` is odd, one byte is enqueued, taken from `bus_rdata[15:8]`. If it is even, two bytes are enqueued: `bus_rdata[7:0]` first, then `bus_rdata[15:8]`.
- R5: The next fetch address advances by the number of bytes accepted, modulo 2^20. An odd target is therefore followed by an even fetch address.
- R6: `redirect` empties the queue and sets the next fetch address to `redirect_addr`. A read requested in the same cycle is not performed.
- R7: Return data for a fetch that was outstanding when a redirect arrived is discarded and never reaches `rd_data`.
- R8: Bytes leave in ascending address order starting at the last target. `rd_data` is valid while `rd_valid` is high. A read (`rd_en` with `rd_valid`) removes exactly one byte.
- R9: A read from an empty queue is stalled: `rd_valid` is low and nothing is removed.
- R10: `q_status` is registered and describes the previous cycle: 2'b10 after a redirect, 2'b01 after a read with `rd_first` high, 2'b11 after a read with `rd_first` low, and 2'b00 otherwise. A redirect takes priority over a read.
- R11: After reset the queue is empty, `q_status` is 2'b00, and the first fetch goes to address 20'hFFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect | input | 1 | Flush and restart at a new target |
| redirect_addr | input | 20 | New fetch target |
| fetch_req | output | 1 | Code fetch request, held until data returns |
| fetch_addr | output | 20 | Byte address of the requested fetch |
| bus_rvalid | input | 1 | Return data valid; ends the request |
| bus_rdata | input | 16 | Aligned 16-bit word holding the requested byte(s) |
| rd_en | input | 1 | Decoder takes one byte |
| rd_first | input | 1 | The taken byte is the first byte of an opcode |
| rd_valid | output | 1 | The queue holds at least one byte |
| rd_data | output | 8 | Oldest queued byte |
| q_status | output | 2 | Queue operation code for the previous cycle |

## Verification
A redirect can fall in the same cycle as a decoder read, and also in the same cycle as returning fetch data. Random stimulus with frequent redirects and a bus latency of zero to three cycles produces both overlaps, and directed steps add more. In the first case the bench expects status 2'b10 and no byte consumed. In the second case it expects the returned bytes never to appear. A reference model of the occupancy and of the expected next byte address judges every later read.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fetch_state_t;

    typedef enum logic [1:0] {
        QS_NONE    = 2'b00,
        QS_FIRST   = 2'b01,
        QS_EMPTIED = 2'b10,
        QS_NEXT    = 2'b11
    } qstat_t;

endpackage

// File: rtl/pfq_fetch_fsm.sv
module pfq_fetch_fsm
    import pfq_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              DEPTH      = 6,
    parameter int              CNT_W      = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic [CNT_W-1:0]  occ,
    input  logic              bus_rvalid,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        wr_cnt,
    output logic [BYTE_W-1:0] wr_b0,
    output logic [BYTE_W-1:0] wr_b1
);

    localparam logic [CNT_W-1:0] ISSUE_MAX = CNT_W'(DEPTH - 2);

    fetch_state_t      state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              accept;
    logic              odd;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (!flush && occ <= ISSUE_MAX) state_d = FS_WAIT;
            FS_WAIT: begin
                if (flush)           state_d = bus_rvalid ? FS_IDLE : FS_DROP;
                else if (bus_rvalid) state_d = FS_IDLE;
            end
            FS_DROP: if (bus_rvalid) state_d = FS_IDLE;
            default: state_d = FS_IDLE;
        endcase
    end

    // state register and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FS_IDLE;
            pc_q       <= RESET_ADDR;
            req_addr_q <= RESET_ADDR;
        end else begin
            state_q <= state_d;
            if (flush)
                pc_q <= flush_addr;
            else if (accept)
                pc_q <= pc_q + ADDR_W'(wr_cnt);
            if (state_q == FS_IDLE && state_d == FS_WAIT)
                req_addr_q <= pc_q;
        end
    end

    // outputs
    always_comb begin
        odd        = req_addr_q[0];
        fetch_req  = (state_q != FS_IDLE);
        fetch_addr = req_addr_q;
        accept     = (state_q == FS_WAIT) && bus_rvalid && !flush;
        wr_cnt     = accept ? (odd ? 2'd1 : 2'd2) : 2'd0;
        wr_b0      = odd ? bus_rdata[WORD_W-1:BYTE_W] : bus_rdata[BYTE_W-1:0];
        wr_b1      = bus_rdata[WORD_W-1:BYTE_W];
    end

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [1:0]        wr_cnt,
    input  logic [BYTE_W-1:0] wr_b0,
    input  logic [BYTE_W-1:0] wr_b1,
    input  logic              rd_req,
    output logic [CNT_W-1:0]  occ,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              took
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0]          wr_ptr_q, rd_ptr_q, wr_ptr1, wr_ptr2;
    logic [CNT_W-1:0]          occ_q;
    logic [DEPTH*BYTE_W-1:0]   flat;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_ptr1 = wrap_inc(wr_ptr_q);
    assign wr_ptr2 = wrap_inc(wr_ptr1);

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            logic [BYTE_W-1:0] slot_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slot_q <= '0;
                else if (wr_cnt != 2'd0 && wr_ptr_q == PTR_W'(s))
                    slot_q <= wr_b0;
                else if (wr_cnt == 2'd2 && wr_ptr1 == PTR_W'(s))
                    slot_q <= wr_b1;
            end
            assign flat[s*BYTE_W +: BYTE_W] = slot_q;
        end
    endgenerate

    assign rd_valid = (occ_q != '0);
    assign took     = rd_req && rd_valid && !flush;
    assign rd_data  = flat[int'(rd_ptr_q)*BYTE_W +: BYTE_W];
    assign occ      = occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (wr_cnt == 2'd1)      wr_ptr_q <= wr_ptr1;
            else if (wr_cnt == 2'd2) wr_ptr_q <= wr_ptr2;
            if (took)                rd_ptr_q <= wrap_inc(rd_ptr_q);
            occ_q <= occ_q + CNT_W'(wr_cnt) - CNT_W'(took);
        end
    end

endmodule

// File: rtl/pfq_status_enc.sv
module pfq_status_enc
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       took,
    input  logic       first,
    output logic [1:0] q_status
);

    qstat_t stat_q, stat_d;

    always_comb begin
        if (flush)     stat_d = QS_EMPTIED;
        else if (took) stat_d = first ? QS_FIRST : QS_NEXT;
        else           stat_d = QS_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= QS_NONE;
        else        stat_q <= stat_d;
    end

    assign q_status = stat_q;

endmodule

// File: rtl/pfq_top.sv
module pfq_top
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 20,
    parameter int                DEPTH      = 6,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              bus_rvalid,
    input  logic [15:0]       bus_rdata,
    input  logic              rd_en,
    input  logic              rd_first,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [1:0]        q_status
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  occ;
    logic [1:0]        wr_cnt;
    logic [BYTE_W-1:0] wr_b0, wr_b1;
    logic              took;

    pfq_fetch_fsm #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(redirect), .flush_addr(redirect_addr),
        .occ(occ), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .wr_cnt(wr_cnt), .wr_b0(wr_b0), .wr_b1(wr_b1)
    );

    pfq_byte_ring #(
        .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(redirect),
        .wr_cnt(wr_cnt), .wr_b0(wr_b0), .wr_b1(wr_b1),
        .rd_req(rd_en), .occ(occ), .rd_valid(rd_valid),
        .rd_data(rd_data), .took(took)
    );

    pfq_status_enc u_stat (
        .clk(clk), .rst_n(rst_n), .flush(redirect),
        .took(took), .first(rd_first), .q_status(q_status)
    );

endmodule

// File: rtl/pfq_top_chk.sv
module pfq_top_chk #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             redirect,
    input logic             fetch_req,
    input logic [19:0]      fetch_addr,
    input logic             bus_rvalid,
    input logic             rd_en,
    input logic             rd_first,
    input logic             rd_valid,
    input logic [1:0]       q_status,
    input logic [CNT_W-1:0] occ
);

    assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_issue_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> $past(occ) <= CNT_W'(DEPTH - 2));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !bus_rvalid) |=> (fetch_req && $stable(fetch_addr)));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !rd_valid);

    assert_empty_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !redirect) |=> q_status == 2'b00);

    assert_flush_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> q_status == 2'b10);

    assert_first_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid && !redirect && rd_first) |=> q_status == 2'b01);

    assert_next_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid && !redirect && !rd_first) |=> q_status == 2'b11);

endmodule

bind pfq_top pfq_top_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .bus_rvalid(bus_rvalid), .rd_en(rd_en),
    .rd_first(rd_first), .rd_valid(rd_valid), .q_status(q_status), .occ(occ)
);

// File: tb/pfq_top_test.sv
`timescale 1ns/1ps
module pfq_top_test;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect = 1'b0;
    logic [19:0] redirect_addr = '0;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic        bus_rvalid = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        rd_en = 1'b0;
    logic        rd_first = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [1:0]  q_status;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int          occ;
    logic [19:0] exp_pc, exp_faddr;
    bit          stale, pend, bus_hold, last_valid;
    int          lat;
    bit          p_fl, p_took, p_first, p_req, p_rv, p_drop;
    int          p_enq, p_occ;
    logic [19:0] p_tgt, p_faddr;

    always #(CLK_P/2) clk = ~clk;

    pfq_top uut (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_addr(redirect_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .rd_en(rd_en), .rd_first(rd_first),
        .rd_valid(rd_valid), .rd_data(rd_data), .q_status(q_status)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'hA};
    endfunction

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return {mem_byte(a | 20'h1), mem_byte(a & ~20'h1)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit rd, input bit fst, input bit fl, input logic [19:0] tgt);
        logic [1:0] exp_st;
        bit rv, took;
        int enq;
        @(negedge clk);
        if (p_fl) begin
            occ = 0; exp_pc = p_tgt; exp_faddr = p_tgt;
        end else begin
            occ = occ + p_enq - int'(p_took);
            exp_pc = exp_pc + 20'(p_took);
            exp_faddr = exp_faddr + 20'(p_enq);
        end
        exp_st = p_fl ? 2'b10 : (p_took ? (p_first ? 2'b01 : 2'b11) : 2'b00);
        chk(q_status == exp_st, "R10 status code", 32'(q_status), 32'(exp_st));
        if (occ == 0)
            chk(rd_valid == 1'b0, "R9 empty queue stalls", 32'(rd_valid), 0);
        else if (p_drop)
            chk(rd_valid == 1'b1, "R7 stale data dropped", 32'(rd_valid), 1);
        else
            chk(rd_valid == 1'b1, "R8 valid while bytes queued", 32'(rd_valid), 1);
        if (p_fl) chk(!rd_valid, "R6 redirect empties queue", 32'(rd_valid), 0);
        if (fetch_req && !p_req) begin
            chk(p_occ <= 4, "R2 room at issue", 32'(p_occ), 4);
            chk(fetch_addr == exp_faddr, "R5 fetch address", 32'(fetch_addr), 32'(exp_faddr));
        end
        if (!fetch_req && !p_req && !p_fl && p_occ <= 4)
            chk(1'b0, "R2 prompt issue", 0, 1);
        if (p_req && !p_rv)
            chk(fetch_req && fetch_addr == p_faddr, "R3 request held",
                32'(fetch_addr), 32'(p_faddr));
        // bus model
        rv = 1'b0; enq = 0; p_drop = 1'b0;
        if (fetch_req && !pend) begin pend = 1'b1; lat = int'($urandom % 4); end
        if (pend && !bus_hold) begin
            if (lat == 0) begin rv = 1'b1; pend = 1'b0; end
            else lat--;
        end
        bus_rvalid = rv;
        bus_rdata  = rv ? mem_word(fetch_addr) : 16'h0;
        if (rv) begin
            if (!stale && !fl) enq = fetch_addr[0] ? 1 : 2;
            else p_drop = 1'b1;
            stale = 1'b0;
        end else if (fl && fetch_req) stale = 1'b1;
        took = rd && rd_valid && !fl;
        if (took)
            chk(rd_data == mem_byte(exp_pc), "R4 R8 byte order", 32'(rd_data), 32'(mem_byte(exp_pc)));
        last_valid = rd_valid;
        rd_en = rd; rd_first = fst; redirect = fl; redirect_addr = tgt;
        p_fl = fl; p_tgt = tgt; p_took = took; p_first = fst; p_enq = enq;
        p_occ = occ; p_req = fetch_req; p_rv = rv; p_faddr = fetch_addr;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int nvalid;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!fetch_req, "R11 no fetch in reset", 32'(fetch_req), 0);
        chk(!rd_valid, "R11 empty in reset", 32'(rd_valid), 0);
        chk(q_status == 2'b00, "R11 status in reset", 32'(q_status), 0);
        rst_n = 1'b1;
        occ = 0; exp_pc = 20'hFFFF0; exp_faddr = 20'hFFFF0;
        stale = 0; pend = 0; bus_hold = 0; lat = 0;
        p_fl = 0; p_took = 0; p_first = 0; p_req = 0; p_rv = 0; p_drop = 0;
        p_enq = 0; p_occ = 0; p_tgt = '0; p_faddr = '0;
        step(0, 0, 0, '0);
        chk(fetch_addr == 20'hFFFF0, "R11 first fetch address", 32'(fetch_addr), 32'hFFFF0);

        // fill with no reads, then stall the bus and drain
        repeat (30) step(0, 0, 0, '0);
        chk(!fetch_req, "R2 full queue stops fetching", 32'(fetch_req), 0);
        bus_hold = 1'b1;
        nvalid = 0;
        for (int i = 0; i < 8; i++) begin
            step(1, (i == 0), 0, '0);
            if (last_valid) nvalid++;
        end
        chk(nvalid == 6, "R1 capacity six bytes", 32'(nvalid), 6);
        bus_hold = 1'b0;

        // odd target, then alignment
        step(0, 0, 1, 20'h00123);
        repeat (12) step(1, 0, 0, '0);
        // wrap at top of address space
        step(1, 1, 1, 20'hFFFFF);
        repeat (12) step(1, 0, 0, '0);
        // redirect with read in same cycle on a non-empty queue
        repeat (6) step(0, 0, 0, '0);
        step(1, 1, 1, 20'h0ABC4);
        step(1, 1, 0, '0);
        // redirect while a fetch waits on a stalled bus
        bus_hold = 1'b1;
        step(0, 0, 1, 20'h12345);
        repeat (3) step(0, 0, 0, '0);
        step(0, 0, 1, 20'h54320);
        bus_hold = 1'b0;
        repeat (10) step(1, 0, 0, '0);

        for (int i = 0; i < 5000; i++)
            step(($urandom % 10) < 6, 1'($urandom % 2), ($urandom % 40) == 0, 20'($urandom));

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule